// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Pin Interrupts

This block is a general-purpose I/O controller on an APB3 register port. It has up to four ports of pins. Each port has three registers: an output value register, a direction register, and a read-only register that returns the pin inputs after a two-flop synchroniser. The direction register drives the output-enable vector one bit per pin. The output value register drives the output vector.

Port A also has a per-pin interrupt unit. Software chooses for each pin:
- whether it may interrupt at all (enable);
- whether it is hidden (mask);
- whether it senses a level or an edge (type);
- which sense is active (polarity).

Edges are held in a sticky latch until software writes ones to a clear register. A mask bit hides a pin from the status register and from the combined interrupt line, but a pending edge is kept. A per-pin filter can be switched on for each port A pin. It ignores changes that last fewer than a fixed number of system clocks.

Top module: `gpio_apb_irq`

## Requirements
- R1: Word offsets are as follows:
  - Port p has its output value register at 0x0C·p and its direction register at 0x0C·p+4.
  - The interrupt registers are enable 0x30, mask 0x34, type 0x38, polarity 0x3C, status 0x40, filter enable 0x48 and clear 0x4C.
  - Each of these registers reads back the value last written, except status (read-only) and clear (reads 0).
- R2: Bits [p·W +: W] of `gpio_oe` equal port p's direction register, and the same bits of `gpio_out` equal port p's output value register.
- R3: The pin register of port p, at 0x50+4·p, returns `gpio_in[p·W +: W]` through two flops. Writes to it have no effect on what it reads.
- R4: After reset every register reads 0, `irq` is 0 and `gpio_oe` is 0. `pready` is always 1 and `pslverr` is always 0.
- R5: A port A pin whose type bit is 1 (level) gives a status bit that is 1 while the pin equals its polarity bit. Writing the clear register does not remove it.
- R6: A port A pin whose type bit is 0 (edge) latches a rising edge when its polarity bit is 1, or a falling edge when it is 0. The latch stays set until a 1 is written to its bit of the clear register at 0x4C.
- R7: An edge that arrives in the same cycle as a clear of the same bit leaves the latch set.
- R8: An edge on a pin whose enable bit is 0 is not latched. Status bit i equals the raw state ANDed with enable bit i and with the inverse of mask bit i.
- R9: A mask bit of 1 removes the pin from status and `irq` but keeps its pending edge. The pending edge shows again when the mask bit returns to 0.
- R10: With its filter enable bit set, a port A pin must hold a new value for 4 consecutive clocks before the interrupt logic sees it. A pulse of 3 clocks is ignored.
- R11: `irq` is the OR of all status bits. Status bit i belongs to port A pin i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | System clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 7 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never signals an error |
| gpio_in | input | NUM_PORTS·PORT_W | Pin inputs |
| gpio_out | output | NUM_PORTS·PORT_W | Output values |
| gpio_oe | output | NUM_PORTS·PORT_W | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
Two cases are hardest to reach from the ports.

The first is an edge that lands in the same clock as a clear write to that bit. The bench reaches it by changing the pin exactly one cycle before starting a two-phase APB write. The write then commits on the third clock edge after the pin change, which is the edge on which the synchroniser and the edge detector latch the event.

The second is the interplay of masking, enabling, type changes and pending edges over long histories. Random configuration writes and random pin toggles are checked against a bench model of the sticky latches. Directed pulses of 3 and 4 clocks probe the filter threshold.

// File: rtl/gpio_apb_irq_pkg.sv
package gpio_apb_irq_pkg;

  localparam logic [6:0] OFS_IRQ_EN    = 7'h30;
  localparam logic [6:0] OFS_IRQ_MASK  = 7'h34;
  localparam logic [6:0] OFS_IRQ_LEVEL = 7'h38;
  localparam logic [6:0] OFS_IRQ_POL   = 7'h3C;
  localparam logic [6:0] OFS_IRQ_STAT  = 7'h40;
  localparam logic [6:0] OFS_FILT_EN   = 7'h48;
  localparam logic [6:0] OFS_IRQ_CLR   = 7'h4C;

  // per-port register locations
  function automatic logic [6:0] data_ofs(int p);
    return 7'(p * 12);
  endfunction

  function automatic logic [6:0] dir_ofs(int p);
    return 7'(p * 12 + 4);
  endfunction

  function automatic logic [6:0] pin_ofs(int p);
    return 7'(80 + p * 4);
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      q       <= '0;
    end else begin
      stage_q <= d;
      q       <= stage_q;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W    = 32,
  parameter int HOLD = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        q[i]  <= 1'b0;
      end else if (d[i] == q[i]) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        q[i]  <= d[i];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] level,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] evt,
  output logic [W-1:0] lat,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] prev_q;

  function automatic logic [W-1:0] edge_hits(logic [W-1:0] lv, logic [W-1:0] pl,
                                             logic [W-1:0] cur, logic [W-1:0] old);
    return ~lv & ((pl & cur & ~old) | (~pl & ~cur & old));
  endfunction

  function automatic logic [W-1:0] raw_state(logic [W-1:0] lv, logic [W-1:0] pl,
                                             logic [W-1:0] cur, logic [W-1:0] held);
    return (lv & ~(cur ^ pl)) | (~lv & held);
  endfunction

  assign evt = edge_hits(level, pol, pin, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat    <= '0;
    end else begin
      prev_q <= pin;
      lat    <= ((lat & ~clr) | (evt & en)) & ~level;
    end
  end

  assign status = raw_state(level, pol, pin, lat) & en & ~mask;
  assign irq    = |status;
endmodule

// File: rtl/gpio_apb_irq.sv
module gpio_apb_irq
  import gpio_apb_irq_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int DEB_HOLD  = 4
) (
  input  logic                          pclk,
  input  logic                          presetn,
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [6:0]                    paddr,
  input  logic [31:0]                   pwdata,
  output logic [31:0]                   prdata,
  output logic                          pready,
  output logic                          pslverr,
  input  logic [NUM_PORTS*PORT_W-1:0]   gpio_in,
  output logic [NUM_PORTS*PORT_W-1:0]   gpio_out,
  output logic [NUM_PORTS*PORT_W-1:0]   gpio_oe,
  output logic                          irq
);
  localparam int PINS = NUM_PORTS * PORT_W;

  logic              wr_en;
  logic [PORT_W-1:0] wval;
  logic [PORT_W-1:0] data_q [NUM_PORTS];
  logic [PORT_W-1:0] dir_q  [NUM_PORTS];
  logic [PORT_W-1:0] en_q, mask_q, lvl_q, pol_q, filt_en_q;
  logic [PORT_W-1:0] eoi_clr;
  logic [PINS-1:0]   pin_sync;
  logic [PORT_W-1:0] pin_filt;
  logic [PORT_W-1:0] pin_src;
  logic [PORT_W-1:0] a_evt, a_lat, a_status;
  logic [PORT_W-1:0] evt_en;
  logic [31:0]       rd_val;

  assign wr_en   = psel & penable & pwrite;
  assign wval    = pwdata[PORT_W-1:0];
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
        data_q[p] <= '0;
        dir_q[p]  <= '0;
      end else if (wr_en) begin
        if (paddr == data_ofs(p)) data_q[p] <= wval;
        if (paddr == dir_ofs(p))  dir_q[p]  <= wval;
      end
    end
    assign gpio_out[p*PORT_W +: PORT_W] = data_q[p];
    assign gpio_oe[p*PORT_W +: PORT_W]  = dir_q[p];
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      en_q      <= '0;
      mask_q    <= '0;
      lvl_q     <= '0;
      pol_q     <= '0;
      filt_en_q <= '0;
    end else if (wr_en) begin
      case (paddr)
        OFS_IRQ_EN:    en_q      <= wval;
        OFS_IRQ_MASK:  mask_q    <= wval;
        OFS_IRQ_LEVEL: lvl_q     <= wval;
        OFS_IRQ_POL:   pol_q     <= wval;
        OFS_FILT_EN:   filt_en_q <= wval;
        default: ;
      endcase
    end
  end

  assign eoi_clr = (wr_en && paddr == OFS_IRQ_CLR) ? wval : '0;

  gpio_sync #(.W(PINS)) u_sync (
    .clk(pclk), .rst_n(presetn), .d(gpio_in), .q(pin_sync)
  );

  gpio_debounce #(.W(PORT_W), .HOLD(DEB_HOLD)) u_filt (
    .clk(pclk), .rst_n(presetn), .d(pin_sync[PORT_W-1:0]), .q(pin_filt)
  );

  assign pin_src = (filt_en_q & pin_filt) | (~filt_en_q & pin_sync[PORT_W-1:0]);

  gpio_irq_unit #(.W(PORT_W)) u_irq (
    .clk(pclk), .rst_n(presetn), .pin(pin_src),
    .en(en_q), .mask(mask_q), .level(lvl_q), .pol(pol_q), .clr(eoi_clr),
    .evt(a_evt), .lat(a_lat), .status(a_status), .irq(irq)
  );

  assign evt_en = a_evt & en_q;

  always_comb begin
    rd_val = '0;
    if (psel && !pwrite) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (paddr == data_ofs(p)) rd_val = 32'(data_q[p]);
        if (paddr == dir_ofs(p))  rd_val = 32'(dir_q[p]);
        if (paddr == pin_ofs(p))  rd_val = 32'(pin_sync[p*PORT_W +: PORT_W]);
      end
      case (paddr)
        OFS_IRQ_EN:    rd_val = 32'(en_q);
        OFS_IRQ_MASK:  rd_val = 32'(mask_q);
        OFS_IRQ_LEVEL: rd_val = 32'(lvl_q);
        OFS_IRQ_POL:   rd_val = 32'(pol_q);
        OFS_IRQ_STAT:  rd_val = 32'(a_status);
        OFS_FILT_EN:   rd_val = 32'(filt_en_q);
        default: ;
      endcase
    end
  end

  assign prdata = rd_val;
endmodule

// File: rtl/gpio_apb_irq_chk.sv
module gpio_apb_irq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] sync_a,
  input logic [W-1:0] filt_a,
  input logic [W-1:0] lat,
  input logic [W-1:0] clr,
  input logic [W-1:0] level,
  input logic [W-1:0] evt_en,
  input logic [W-1:0] en,
  input logic         irq
);
  // R6: a latched edge survives unless cleared or switched to level sensing
  a_r6_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(lat) & ~$past(clr) & ~$past(level)) & ~lat) == '0));

  // R7: an enabled edge always lands in the latch, even against a clear
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_en) & ~lat) == '0));

  // R10: the filtered pin only ever moves to the value the synchroniser held
  a_r10_filt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (((filt_a ^ $past(filt_a)) & (filt_a ^ $past(sync_a))) == '0));

  // R8: with nothing enabled the combined line stays low
  a_r8_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

bind gpio_apb_irq gpio_apb_irq_chk #(.W(PORT_W)) u_chk (
  .clk(pclk), .rst_n(presetn),
  .sync_a(pin_sync[PORT_W-1:0]), .filt_a(pin_filt),
  .lat(a_lat), .clr(eoi_clr), .level(lvl_q),
  .evt_en(evt_en), .en(en_q), .irq(irq)
);

// File: tb/gpio_apb_irq_tb.sv
`timescale 1ns/1ps
module gpio_apb_irq_tb;
  localparam int NP = 4;
  localparam int W  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [6:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, irq;
  logic [NP*W-1:0] gpio_in = '0;
  logic [NP*W-1:0] gpio_out, gpio_oe;

  int n_chk = 0, n_bad = 0;

  // bench model of port A interrupt state
  logic [31:0] m_en = 0, m_mask = 0, m_lvl = 0, m_pol = 0, m_lat = 0, m_pin = 0;

  always #2 clk = ~clk;

  gpio_apb_irq u_dut (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return m_en & ~m_mask & ((m_lvl & ~(m_pin ^ m_pol)) | (~m_lvl & m_lat));
  endfunction

  function automatic logic [31:0] exp_edges(logic [31:0] was, logic [31:0] now);
    return ~m_lvl & m_en & ((m_pol & now & ~was) | (~m_pol & ~now & was));
  endfunction

  task automatic apb_wr(logic [6:0] a, logic [31:0] d);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(logic [6:0] a, output logic [31:0] d);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic cfg(logic [6:0] a, logic [31:0] d);
    apb_wr(a, d);
    case (a)
      7'h30: m_en = d;
      7'h34: m_mask = d;
      7'h38: m_lvl = d;
      7'h3C: m_pol = d;
      7'h4C: m_lat = m_lat & ~d;
      default: ;
    endcase
    m_lat = m_lat & ~m_lvl;
  endtask

  task automatic set_pin(logic [31:0] v);
    m_lat = m_lat | exp_edges(m_pin, v);
    m_pin = v;
    gpio_in[W-1:0] = v;
    repeat (10) @(negedge clk);
  endtask

  task automatic check_irq_state(string tag);
    logic [31:0] s;
    apb_rd(7'h40, s);
    check({tag, " status"}, s, exp_status());
    check({tag, " R11 irq"}, {31'b0, irq}, {31'b0, |exp_status()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r, v;
    logic seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R4 reset state
    apb_rd(7'h30, r); check("R4 enable reset", r, 0);
    apb_rd(7'h38, r); check("R4 type reset", r, 0);
    apb_rd(7'h40, r); check("R4 status reset", r, 0);
    apb_rd(7'h0C, r); check("R4 port B data reset", r, 0);
    check("R4 oe reset", gpio_oe[31:0] | gpio_oe[127:96], 0);
    check("R4 irq reset", {31'b0, irq}, 0);
    check("R4 ready/err", {30'b0, pready, pslverr}, 32'h2);

    // R1 R2 port output/direction registers
    for (int p = 0; p < NP; p++) begin
      logic [31:0] dv, ov;
      dv = $urandom; ov = $urandom;
      apb_wr(7'(p*12), ov);
      apb_wr(7'(p*12+4), dv);
      apb_rd(7'(p*12), r);   check("R1 data readback", r, ov);
      apb_rd(7'(p*12+4), r); check("R1 dir readback", r, dv);
      check("R2 gpio_out", gpio_out[p*W +: W], ov);
      check("R2 gpio_oe", gpio_oe[p*W +: W], dv);
    end
    v = $urandom;
    apb_wr(7'h48, v); apb_rd(7'h48, r); check("R1 filter readback", r, v);
    apb_wr(7'h48, 0);
    apb_rd(7'h4C, r); check("R1 clear reads zero", r, 0);

    // R3 pin registers, writes ignored
    for (int p = 1; p < NP; p++) gpio_in[p*W +: W] = $urandom;
    repeat (3) @(negedge clk);
    for (int p = 1; p < NP; p++) begin
      apb_wr(7'(80 + 4*p), ~gpio_in[p*W +: W]);
      apb_rd(7'(80 + 4*p), r);
      check("R3 pin register", r, gpio_in[p*W +: W]);
    end

    // R5 level interrupt on bit 0, active high
    cfg(7'h38, 32'h1); cfg(7'h3C, 32'h1); cfg(7'h30, 32'h1);
    check_irq_state("R5 idle");
    set_pin(32'h1);
    check_irq_state("R5 high");
    check("R5 status bit0", exp_status(), 32'h1);
    cfg(7'h4C, 32'hFFFF_FFFF);
    check_irq_state("R5 clear ignored");
    set_pin(32'h0);
    check_irq_state("R5 low");

    // R6 edge: bit1 rising, bit2 falling
    cfg(7'h38, 32'h0); cfg(7'h3C, 32'h2); cfg(7'h30, 32'h6);
    set_pin(32'h4);   // bit2 rises (no), bit1 steady
    check_irq_state("R6 wrong-direction edge");
    check("R6 none latched", exp_status(), 0);
    set_pin(32'h2);   // bit1 rises, bit2 falls
    check_irq_state("R6 both latched");
    check("R6 bits", exp_status(), 32'h6);
    set_pin(32'h0);
    check_irq_state("R6 sticky");
    cfg(7'h4C, 32'h2);
    check_irq_state("R6 partial clear");
    cfg(7'h4C, 32'h4);
    check_irq_state("R6 cleared");
    check("R6 empty", exp_status(), 0);

    // R7 edge in the same cycle as its clear
    gpio_in[1] = 1'b1;        // rising edge on bit1, latched on 3rd posedge
    m_lat = m_lat | exp_edges(m_pin, 32'h2); m_pin = 32'h2;
    @(negedge clk);
    apb_wr(7'h4C, 32'h2);     // commits on that same posedge
    repeat (3) @(negedge clk);
    check_irq_state("R7 edge wins");
    check("R7 bit1 set", exp_status(), 32'h2);
    cfg(7'h4C, 32'h2);
    check_irq_state("R7 later clear");

    // R9 mask keeps pending edge
    set_pin(32'h0);
    set_pin(32'h2);
    cfg(7'h34, 32'hFFFF_FFFF);
    check_irq_state("R9 masked");
    check("R9 masked irq", {31'b0, irq}, 0);
    cfg(7'h34, 32'h0);
    check_irq_state("R9 unmasked");
    check("R9 pending shown", exp_status(), 32'h2);
    cfg(7'h4C, 32'hFFFF_FFFF);

    // R8 disabled pin edge not latched
    cfg(7'h30, 32'h0);
    set_pin(32'h0);
    set_pin(32'h2);
    cfg(7'h30, 32'h2);
    check_irq_state("R8 disabled edge dropped");
    check("R8 nothing pending", exp_status(), 0);

    // R10 filter on bit3, level active high
    set_pin(32'h0);
    cfg(7'h30, 32'h0); cfg(7'h4C, 32'hFFFF_FFFF);
    cfg(7'h38, 32'h8); cfg(7'h3C, 32'h8); cfg(7'h48, 32'h8); cfg(7'h30, 32'h8);
    seen = 1'b0;
    gpio_in[3] = 1'b1;
    repeat (3) @(negedge clk);
    gpio_in[3] = 1'b0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); seen |= irq; end
    check("R10 3-clock pulse ignored", {31'b0, seen}, 0);
    gpio_in[3] = 1'b1;
    repeat (4) @(negedge clk);
    gpio_in[3] = 1'b0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); seen |= irq; end
    check("R10 4-clock pulse seen", {31'b0, seen}, 1);
    cfg(7'h48, 32'h0);
    seen = 1'b0;
    gpio_in[3] = 1'b1;
    @(negedge clk);
    gpio_in[3] = 1'b0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); seen |= irq; end
    check("R10 unfiltered 1-clock pulse seen", {31'b0, seen}, 1);

    // random mix of configuration, clears and pin toggles
    for (int it = 0; it < 60; it++) begin
      int op;
      op = int'($urandom % 6);
      v = $urandom;
      case (op)
        0: cfg(7'h30, v);
        1: cfg(7'h34, v & $urandom);
        2: cfg(7'h38, v);
        3: cfg(7'h3C, v);
        4: apb_wr(7'h48, v);
        default: cfg(7'h4C, v);
      endcase
      set_pin(m_pin ^ ($urandom & $urandom));
      check_irq_state("R8 R9 R11 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule